// File: doc/BRIEF.md
# Flag-Generating Integer ALU

This block is an integer arithmetic/logic unit for byte, half-word (16-bit) and full-word (32-bit) operands. It computes add, add-with-carry, subtract, subtract-with-borrow, AND, OR, XOR, negate, increment, decrement and bitwise NOT. Alongside each result it produces the six arithmetic status flags, following the conventions of classic accumulator-style processors:

- auxiliary carry is taken out of bit 4;
- parity covers only the low result byte;
- increment and decrement leave carry alone;
- negate reports carry whenever its operand was nonzero;
- the logic operations clear overflow.

The result is combinational from the operand, size and opcode inputs. The flags live in a small register inside the block. That register loads the newly computed flags on any clock edge where `op_valid_i` is high. Its carry bit is the carry-in for add-with-carry and subtract-with-borrow, so multi-word chains can be issued on back-to-back cycles.

Top module: `flagged_alu`

## Requirements
- R1: While `rst_n` is low, and after its release until the first valid operation, `flags_o` is all zero. The flag bits are [0] carry, [1] parity, [2] auxiliary, [3] zero, [4] sign, [5] overflow.
- R2: `size_i` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operands are truncated to the active width, and `result_o` is zero above the active width for every opcode.
- R3: Opcode 0 (add) and opcode 2 (add with carry-in = stored carry) produce dst+src+cin. Carry is set on unsigned carry out of the active width. Overflow is set when the signed sum leaves the signed range of the width.
- R4: Opcode 5 (subtract) and opcode 3 (subtract with borrow-in = stored carry) produce dst-src-cin. Carry is set when dst < src+cin unsigned. Overflow is set when the signed difference leaves the signed range.
- R5: For add, adc, sub, sbb, inc, dec and neg, the auxiliary flag is the carry or borrow across bit 3 into bit 4.
- R6: Zero and sign are taken from the truncated result. Parity is 1 when the low 8 bits of the result hold an even number of ones, at every width.
- R7: Opcodes 4 (AND), 1 (OR) and 6 (XOR) clear carry, overflow and auxiliary.
- R8: Opcode 8 (increment) and opcode 9 (decrement) keep the stored carry. Increment overflows only from the largest positive value; decrement overflows only from the most negative value.
- R9: Opcode 7 (negate) returns 0-dst. It sets carry exactly when dst is nonzero and sets overflow exactly when dst is the most negative value.
- R10: Opcode 10 inverts dst at the active width and leaves every flag unchanged.
- R11: Opcodes 11 to 15 return dst truncated to the active width and leave every flag unchanged.
- R12: `flags_o` changes only on a rising clock edge with `op_valid_i` high. `result_o` of add-with-carry and subtract-with-borrow uses the carry stored before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_valid_i | input | 1 | Commit the computed flags on this edge |
| opcode_i | input | 4 | Operation select |
| size_i | input | 2 | Operand width select |
| dst_i | input | 32 | First operand (destination) |
| src_i | input | 32 | Second operand (source) |
| result_o | output | 32 | Combinational result, zero above the active width |
| flags_o | output | 6 | Stored flags {OF, SF, ZF, AF, PF, CF} |

## Verification
The directed patterns sit on the boundaries where flag rules differ:
- Largest-positive plus one separates overflow from carry.
- All-ones plus one separates carry from zero at each width.
- A value with an odd total bit count but an even low byte separates true low-byte parity from full-word parity.
- Equal operands with carry-in set exercise the `<=` carry branch of the chained operations.

Increment with carry already set and decrement of the most negative value show carry retention and the overflow rule apart from add and subtract. NOT and the unused codes are issued after flags are set, so an unwanted flag write shows at the port. A long random mix of opcodes, widths and commit strobes then compares every result and every stored flag against a model built on signed and unsigned integer ranges.

// File: rtl/flagged_alu_pkg.sv
package flagged_alu_pkg;

   localparam int FLAG_W = 6;
   localparam int FL_CF  = 0;
   localparam int FL_PF  = 1;
   localparam int FL_AF  = 2;
   localparam int FL_ZF  = 3;
   localparam int FL_SF  = 4;
   localparam int FL_OF  = 5;

   typedef logic [FLAG_W-1:0] flags_t;

   localparam logic [3:0] OPC_ADD = 4'd0;
   localparam logic [3:0] OPC_OR  = 4'd1;
   localparam logic [3:0] OPC_ADC = 4'd2;
   localparam logic [3:0] OPC_SBB = 4'd3;
   localparam logic [3:0] OPC_AND = 4'd4;
   localparam logic [3:0] OPC_SUB = 4'd5;
   localparam logic [3:0] OPC_XOR = 4'd6;
   localparam logic [3:0] OPC_NEG = 4'd7;
   localparam logic [3:0] OPC_INC = 4'd8;
   localparam logic [3:0] OPC_DEC = 4'd9;
   localparam logic [3:0] OPC_NOT = 4'd10;

   typedef enum logic [1:0] {
      CLS_ADD   = 2'd0,
      CLS_SUB   = 2'd1,
      CLS_LOGIC = 2'd2,
      CLS_KEEP  = 2'd3
   } op_class_e;

endpackage

// File: rtl/flagged_alu_size_dec.sv
module flagged_alu_size_dec #(
   parameter int DATA_W    = 32,
   parameter int NUM_SIZES = 3
) (
   input  logic [1:0]           size_i,
   output logic [DATA_W-1:0]    mask_o,
   output logic [NUM_SIZES-1:0] lane_oh_o
);

   localparam int SEL_MAX = NUM_SIZES - 1;

   logic [DATA_W-1:0] lane_mask [NUM_SIZES];

   for (genvar i = 0; i < NUM_SIZES; i++) begin : g_lane
      assign lane_mask[i] = {DATA_W{1'b1}} >> (DATA_W - (8 << i));
   end

   always_comb begin
      int idx;
      idx = (int'(size_i) > SEL_MAX) ? SEL_MAX : int'(size_i);
      lane_oh_o = '0;
      lane_oh_o[idx] = 1'b1;
   end

   always_comb begin
      mask_o = '0;
      for (int i = 0; i < NUM_SIZES; i++) begin
         if (lane_oh_o[i]) mask_o = mask_o | lane_mask[i];
      end
   end

endmodule

// File: rtl/flagged_alu_addsub.sv
module flagged_alu_addsub #(
   parameter int    DATA_W      = 32,
   parameter int    NUM_SIZES   = 3,
   parameter string CARRY_STYLE = "EXT"
) (
   input  logic [DATA_W-1:0]    x_i,
   input  logic [DATA_W-1:0]    y_i,
   input  logic [DATA_W-1:0]    mask_i,
   input  logic                 cin_i,
   input  logic                 sub_i,
   input  logic [NUM_SIZES-1:0] lane_oh_i,
   output logic [DATA_W-1:0]    sum_o,
   output logic                 cout_o
);

   logic [DATA_W:0] ext;
   logic [DATA_W:0] cin_ext;

   assign cin_ext = {{DATA_W{1'b0}}, cin_i};

   always_comb begin
      if (sub_i) ext = {1'b0, x_i} - {1'b0, y_i} - cin_ext;
      else       ext = {1'b0, x_i} + {1'b0, y_i} + cin_ext;
   end

   assign sum_o = ext[DATA_W-1:0] & mask_i;

   if (CARRY_STYLE == "EXT") begin : g_ext
      // Operands arrive zero above the active width, so the bit just past
      // the width is the carry (add) or the borrow (subtract).
      logic [NUM_SIZES-1:0] tap;
      for (genvar i = 0; i < NUM_SIZES; i++) begin : g_tap
         assign tap[i] = ext[8 << i];
      end
      assign cout_o = |(tap & lane_oh_i);
   end else begin : g_cmp
      // Magnitude comparison on the truncated values instead of a wide tap.
      logic add_lt, add_le, sub_lt, sub_le;
      logic unused_lane;
      assign add_lt = sum_o <  y_i;
      assign add_le = sum_o <= y_i;
      assign sub_lt = x_i   <  y_i;
      assign sub_le = x_i   <= y_i;
      assign unused_lane = |lane_oh_i;
      assign cout_o = sub_i ? (cin_i ? sub_le : sub_lt)
                            : (cin_i ? add_le : add_lt);
   end

endmodule

// File: rtl/flagged_alu_flags.sv
module flagged_alu_flags
   import flagged_alu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_SIZES = 3,
   parameter int PAR_BITS  = 8,
   parameter int AUX_BIT   = 4
) (
   input  logic [DATA_W-1:0]    res_i,
   input  logic [DATA_W-1:0]    x_i,
   input  logic [DATA_W-1:0]    y_i,
   input  logic [NUM_SIZES-1:0] lane_oh_i,
   input  op_class_e            cls_i,
   input  logic                 cout_i,
   input  logic                 keep_cf_i,
   input  flags_t               flags_i,
   output flags_t               flags_o
);

   logic [DATA_W-1:0]    ov_vec;
   logic [DATA_W-1:0]    aux_vec;
   logic [NUM_SIZES-1:0] ov_tap;
   logic [NUM_SIZES-1:0] sg_tap;
   logic                 ov_bit, sg_bit, zr_bit, par_bit;

   always_comb begin
      if (cls_i == CLS_SUB) ov_vec = (x_i ^ res_i) & (x_i ^ y_i);
      else                  ov_vec = (res_i ^ x_i) & (res_i ^ y_i);
   end

   assign aux_vec = res_i ^ x_i ^ y_i;

   for (genvar i = 0; i < NUM_SIZES; i++) begin : g_msb
      assign ov_tap[i] = ov_vec[(8 << i) - 1];
      assign sg_tap[i] = res_i[(8 << i) - 1];
   end

   assign ov_bit  = |(ov_tap & lane_oh_i);
   assign sg_bit  = |(sg_tap & lane_oh_i);
   assign zr_bit  = (res_i == '0);
   assign par_bit = ~^res_i[PAR_BITS-1:0];

   always_comb begin
      flags_o = flags_i;
      unique case (cls_i)
         CLS_ADD, CLS_SUB: begin
            flags_o[FL_CF] = keep_cf_i ? flags_i[FL_CF] : cout_i;
            flags_o[FL_AF] = aux_vec[AUX_BIT];
            flags_o[FL_OF] = ov_bit;
            flags_o[FL_ZF] = zr_bit;
            flags_o[FL_SF] = sg_bit;
            flags_o[FL_PF] = par_bit;
         end
         CLS_LOGIC: begin
            flags_o[FL_CF] = 1'b0;
            flags_o[FL_AF] = 1'b0;
            flags_o[FL_OF] = 1'b0;
            flags_o[FL_ZF] = zr_bit;
            flags_o[FL_SF] = sg_bit;
            flags_o[FL_PF] = par_bit;
         end
         default: flags_o = flags_i;
      endcase
   end

endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
   import flagged_alu_pkg::*;
#(
   parameter int    DATA_W      = 32,
   parameter int    PAR_BITS    = 8,
   parameter string CARRY_STYLE = "EXT"
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid_i,
   input  logic [3:0]        opcode_i,
   input  logic [1:0]        size_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   output logic [DATA_W-1:0] result_o,
   output logic [FLAG_W-1:0] flags_o
);

   localparam int NUM_SIZES = $clog2(DATA_W / 8) + 1;
   localparam int AUX_BIT   = 4;

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0 || DATA_W > 64) begin : g_bad_width
      $error("flagged_alu: DATA_W must be a power of two from 8 to 64");
   end
   if (PAR_BITS < 1 || PAR_BITS > 8) begin : g_bad_par
      $error("flagged_alu: PAR_BITS must lie in 1..8");
   end
   if (CARRY_STYLE != "EXT" && CARRY_STYLE != "CMP") begin : g_bad_style
      $error("flagged_alu: CARRY_STYLE must be EXT or CMP");
   end

   logic [DATA_W-1:0]    mask;
   logic [NUM_SIZES-1:0] lane_oh;
   logic [DATA_W-1:0]    dm, sm;
   logic [DATA_W-1:0]    ax, ay, arith_sum, logic_res;
   logic                 cin, sub, cout, keep_cf, use_logic;
   op_class_e            cls;
   flags_t               flags_q, flags_next;

   flagged_alu_size_dec #(
      .DATA_W    (DATA_W),
      .NUM_SIZES (NUM_SIZES)
   ) u_size (
      .size_i    (size_i),
      .mask_o    (mask),
      .lane_oh_o (lane_oh)
   );

   assign dm = dst_i & mask;
   assign sm = src_i & mask;

   always_comb begin
      ax        = dm;
      ay        = sm;
      cin       = 1'b0;
      sub       = 1'b0;
      keep_cf   = 1'b0;
      use_logic = 1'b0;
      logic_res = dm;
      cls       = CLS_KEEP;
      case (opcode_i)
         OPC_ADD: cls = CLS_ADD;
         OPC_ADC: begin cls = CLS_ADD; cin = flags_q[FL_CF]; end
         OPC_SUB: begin cls = CLS_SUB; sub = 1'b1; end
         OPC_SBB: begin cls = CLS_SUB; sub = 1'b1; cin = flags_q[FL_CF]; end
         OPC_NEG: begin cls = CLS_SUB; sub = 1'b1; ax = '0; ay = dm; end
         OPC_INC: begin cls = CLS_ADD; ay = DATA_W'(1); keep_cf = 1'b1; end
         OPC_DEC: begin cls = CLS_SUB; sub = 1'b1; ay = DATA_W'(1); keep_cf = 1'b1; end
         OPC_AND: begin cls = CLS_LOGIC; use_logic = 1'b1; logic_res = dm & sm; end
         OPC_OR:  begin cls = CLS_LOGIC; use_logic = 1'b1; logic_res = dm | sm; end
         OPC_XOR: begin cls = CLS_LOGIC; use_logic = 1'b1; logic_res = dm ^ sm; end
         OPC_NOT: begin use_logic = 1'b1; logic_res = ~dst_i & mask; end
         default: use_logic = 1'b1;
      endcase
   end

   flagged_alu_addsub #(
      .DATA_W      (DATA_W),
      .NUM_SIZES   (NUM_SIZES),
      .CARRY_STYLE (CARRY_STYLE)
   ) u_addsub (
      .x_i       (ax),
      .y_i       (ay),
      .mask_i    (mask),
      .cin_i     (cin),
      .sub_i     (sub),
      .lane_oh_i (lane_oh),
      .sum_o     (arith_sum),
      .cout_o    (cout)
   );

   assign result_o = use_logic ? logic_res : arith_sum;

   flagged_alu_flags #(
      .DATA_W    (DATA_W),
      .NUM_SIZES (NUM_SIZES),
      .PAR_BITS  (PAR_BITS),
      .AUX_BIT   (AUX_BIT)
   ) u_flags (
      .res_i     (result_o),
      .x_i       (ax),
      .y_i       (ay),
      .lane_oh_i (lane_oh),
      .cls_i     (cls),
      .cout_i    (cout),
      .keep_cf_i (keep_cf),
      .flags_i   (flags_q),
      .flags_o   (flags_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_q <= '0;
      else if (op_valid_i) flags_q <= flags_next;
   end

   assign flags_o = flags_q;

endmodule

// File: rtl/flagged_alu_chk.sv
module flagged_alu_chk
   import flagged_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid_i,
   input logic [3:0]        opcode_i,
   input logic [1:0]        size_i,
   input logic [DATA_W-1:0] result_o,
   input logic [FLAG_W-1:0] flags_o
);

   // R1
   always @(negedge clk) begin
      if (!rst_n) begin
         reset_flags_chk: assert (flags_o == '0);
      end
   end

   // R2
   byte_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == 2'd0) |-> (result_o[DATA_W-1:8] == '0));

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid_i |=> $stable(flags_o));

   // R7
   logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && (opcode_i == OPC_AND || opcode_i == OPC_OR || opcode_i == OPC_XOR))
      |=> (flags_o[FL_CF] == 1'b0 && flags_o[FL_OF] == 1'b0 && flags_o[FL_AF] == 1'b0));

   // R8
   incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && (opcode_i == OPC_INC || opcode_i == OPC_DEC))
      |=> (flags_o[FL_CF] == $past(flags_o[FL_CF])));

   // R9
   neg_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && opcode_i == OPC_NEG) |=> (flags_o[FL_CF] == ($past(result_o) != '0)));

   // R10
   // R11
   noflag_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && opcode_i >= OPC_NOT) |=> $stable(flags_o));

   // R6
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && opcode_i < OPC_NOT) |=> (flags_o[FL_ZF] == ($past(result_o) == '0)));

endmodule

bind flagged_alu flagged_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid_i (op_valid_i),
   .opcode_i   (opcode_i),
   .size_i     (size_i),
   .result_o   (result_o),
   .flags_o    (flags_o)
);

// File: tb/flagged_alu_tb.sv
module flagged_alu_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid_i = 1'b0;
   logic [3:0]  opcode_i = '0;
   logic [1:0]  size_i = '0;
   logic [31:0] dst_i = '0;
   logic [31:0] src_i = '0;
   logic [31:0] result_o;
   logic [5:0]  flags_o;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 1'b0;
   bit [5:0] mdl_flags = '0;
   string prev_tag = "R1 reset";

   flagged_alu u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .opcode_i(opcode_i),
      .size_i(size_i), .dst_i(dst_i), .src_i(src_i),
      .result_o(result_o), .flags_o(flags_o)
   );

   always #4 clk = ~clk;

   // Behavioural reference: integer ranges, nibble sums, popcount.
   function automatic void ref_op(input int op, input int sz, input bit [31:0] d32,
                                  input bit [31:0] s32, input bit [5:0] fi,
                                  output bit [31:0] r32, output bit [5:0] fo);
      int     w;
      longint m, half, d, s, r, sd, ss, c, t;
      bit     upd;
      w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
      m    = (longint'(1) << w) - 1;
      half = longint'(1) << (w - 1);
      d    = longint'(d32) & m;
      s    = longint'(s32) & m;
      sd   = (d >= half) ? d - 2 * half : d;
      ss   = (s >= half) ? s - 2 * half : s;
      c    = longint'(fi[0]);
      fo   = fi;
      upd  = 1'b1;
      case (op)
         0, 2: begin
            if (op == 0) c = 0;
            r = d + s + c;
            t = sd + ss + c;
            fo[0] = (r > m);
            fo[5] = (t > half - 1) || (t < -half);
            fo[2] = ((d & 15) + (s & 15) + c) > 15;
         end
         3, 5: begin
            if (op == 5) c = 0;
            r = d - s - c;
            t = sd - ss - c;
            fo[0] = (d < s + c);
            fo[5] = (t > half - 1) || (t < -half);
            fo[2] = (d & 15) < ((s & 15) + c);
         end
         7: begin
            r = -d;
            fo[0] = (d != 0);
            fo[5] = (d == half);
            fo[2] = ((d & 15) != 0);
         end
         8: begin
            r = d + 1;
            fo[5] = (d == half - 1);
            fo[2] = ((d & 15) == 15);
         end
         9: begin
            r = d - 1;
            fo[5] = (d == half);
            fo[2] = ((d & 15) == 0);
         end
         1, 4, 6: begin
            r = (op == 1) ? (d | s) : (op == 4) ? (d & s) : (d ^ s);
            fo[0] = 1'b0; fo[5] = 1'b0; fo[2] = 1'b0;
         end
         10: begin r = ~d; upd = 1'b0; end
         default: begin r = d; upd = 1'b0; end
      endcase
      r = r & m;
      if (upd) begin
         fo[3] = (r == 0);
         fo[4] = (r >= half);
         fo[1] = ($countones(r & 255) % 2) == 0;
      end
      r32 = r[31:0];
   endfunction

   task automatic check_flags(input string tag);
      n_checks++;
      if (flags_o !== mdl_flags) begin
         n_errors++;
         $display("FAIL %s flags: got %b exp %b", tag, flags_o, mdl_flags);
      end
   endtask

   task automatic do_op(input int op, input int sz, input bit [31:0] d,
                        input bit [31:0] s, input bit v, input string tag);
      bit [31:0] er;
      bit [5:0]  ef;
      @(negedge clk);
      check_flags(prev_tag);
      opcode_i = op[3:0]; size_i = sz[1:0]; dst_i = d; src_i = s; op_valid_i = v;
      #1;
      ref_op(op, sz, d, s, mdl_flags, er, ef);
      n_checks++;
      if (result_o !== er) begin
         n_errors++;
         $display("FAIL %s result: got %h exp %h", tag, result_o, er);
      end
      if (v) mdl_flags = ef;
      prev_tag = tag;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_flags("R1 during reset");
      rst_n = 1'b1;
      // R1 after release, no valid op yet
      do_op(0, 0, 32'h1, 32'h1, 1'b0, "R12 idle add");
      do_op(0, 0, 32'h7f, 32'h1, 1'b1, "R3 R5 add byte overflow");
      do_op(0, 0, 32'hff, 32'h1, 1'b1, "R3 R6 add byte carry zero");
      do_op(0, 1, 32'h1234ffff, 32'h1, 1'b1, "R2 R3 add word wrap");
      do_op(0, 2, 32'hffffffff, 32'h1, 1'b1, "R3 add dword carry");
      do_op(2, 2, 32'hffffffff, 32'hffffffff, 1'b1, "R3 adc dword cin1 equal");
      do_op(2, 0, 32'h10, 32'h20, 1'b1, "R3 R12 adc uses stored carry");
      do_op(5, 0, 32'h0, 32'h1, 1'b1, "R4 sub byte borrow");
      do_op(3, 2, 32'h5, 32'h5, 1'b1, "R4 sbb dword equal cin1");
      do_op(5, 1, 32'h8000, 32'h1, 1'b1, "R4 sub word overflow");
      do_op(6, 2, 32'h01000000, 32'h00000003, 1'b1, "R6 R7 xor low byte parity");
      do_op(4, 0, 32'hf0, 32'h0f, 1'b1, "R7 and zero");
      do_op(1, 1, 32'h8000, 32'h0001, 1'b1, "R7 or sign");
      do_op(5, 0, 32'h0, 32'h1, 1'b1, "R4 set carry");
      do_op(8, 1, 32'h7fff, 32'h0, 1'b1, "R8 inc keeps carry overflow");
      do_op(9, 2, 32'h80000000, 32'h0, 1'b1, "R8 dec most negative");
      do_op(4, 0, 32'h0, 32'h0, 1'b1, "R7 clear carry");
      do_op(9, 0, 32'h00, 32'h0, 1'b1, "R8 dec keeps clear carry");
      do_op(7, 0, 32'h0, 32'h0, 1'b1, "R9 neg zero");
      do_op(7, 0, 32'h80, 32'h0, 1'b1, "R9 neg most negative");
      do_op(7, 2, 32'h1, 32'h0, 1'b1, "R9 neg one");
      do_op(10, 0, 32'hfff0, 32'h0, 1'b1, "R10 not byte");
      do_op(10, 2, 32'h12345678, 32'h0, 1'b1, "R10 not dword");
      do_op(12, 1, 32'habcd1234, 32'h0, 1'b1, "R11 unused code");
      do_op(15, 3, 32'h00000000, 32'h0, 1'b1, "R11 unused code zero");
      do_op(0, 3, 32'h7fffffff, 32'h1, 1'b1, "R2 size three");
      do_op(4, 0, 32'h0, 32'h0, 1'b0, "R12 idle and");
      for (int k = 0; k < 600; k++) begin
         int op_r, sz_r;
         op_r = int'($urandom_range(15, 0));
         sz_r = int'($urandom_range(3, 0));
         do_op(op_r, sz_r, $urandom, ($urandom_range(3, 0) == 0) ? 32'h0 : $urandom,
               ($urandom_range(9, 0) != 0), "R2 R3 R4 R5 R6 R12 random");
      end
      @(negedge clk);
      check_flags(prev_tag);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog R12: got timeout exp completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule